// File: doc/BRIEF.md
# Cellular Network Cell Compute Unit

This block is the arithmetic core of one node in a grid of cells that each run a discrete-time cell equation. A start pulse begins a run. The node then takes a stream of neighbour values. The first group of nine values is the input pattern. Each value is weighted by an input-set coefficient, and a bias coefficient is added. The resulting sum is stored once as the constant term. Each later group of nine values holds neighbour outputs. Those values are weighted by the feedback-set coefficients and added to the stored constant. The sum is saturated to eight bits and used as the index into a writable output table. The table entry becomes the new cell output.

Coefficients come from a local template store with 2048 entries. A controller builds each coefficient address from four fields: a base register, a set selector, an input/feedback flag and a four-bit tap index. The only controls the datapath needs are this address and the enables for the accumulator and its multiplexer. Neighbour values arrive over a valid/ready stream. The node raises ready only while it is accumulating. The source must hold a value, and keep it stable, until it is accepted. The node never drops a value it has taken.

Top module: `cell_compute_unit`

## Requirements
- R1: While rst_n is low, and on the first cycle after it rises, y_out is 0 and busy, done and nb_ready are all low.
- R2: The coefficient address is base×64 + set×32 + flag×16 + tap. The flag is 0 for the input set and 1 for the feedback set. Taps 0 to 8 weight the nine values of a group in arrival order, and tap 9 of the input set holds the bias.
- R3: The constant term is the bias plus the sum of input coefficient × value over the first group. It is written once per run and is not changed during the feedback iterations.
- R4: Each feedback iteration starts again from the stored constant and adds feedback coefficient × value over its group. The result of a previous iteration does not carry over.
- R5: The 20-bit signed sum is clamped to the range −128..127. The clamped value, taken as eight two's-complement bits, indexes the output table, and the table entry is loaded into y_out.
- R6: A value is accepted when nb_valid and nb_ready are both high at a clock edge. nb_ready is high only during accumulation. It is low in the cycle after start and low while the node is idle.
- R7: With an iteration count N, a run consumes 9×(N+1) values. done is a one-cycle pulse that arrives together with the final y_out. With N=0, the run only stores the constant and y_out keeps its value.
- R8: A start pulse while busy is high is ignored. Any set, base and count values presented with it have no effect on the run in progress.
- R9: y_out holds its value whenever the node is idle.
- R10: The template store and the output table are loaded through their own write ports, one entry per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run; taken only while idle |
| iter_cnt | input | 4 | Number of feedback iterations |
| set_sel | input | 1 | Template set used by the run |
| tmpl_base | input | 5 | Upper bits of the template address |
| tw_en | input | 1 | Template store write enable |
| tw_addr | input | 11 | Template store write address |
| tw_data | input | 8 | Template coefficient, signed |
| lw_en | input | 1 | Output table write enable |
| lw_addr | input | 8 | Output table write index |
| lw_data | input | 8 | Output table entry |
| nb_valid | input | 1 | Neighbour value present |
| nb_ready | output | 1 | Node accepts a neighbour value |
| nb_data | input | 8 | Neighbour value, signed |
| y_out | output | 8 | Cell output |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse at the end of a run |

## Verification
The embedded properties assume that the neighbour source holds nb_data stable while nb_valid waits for ready. They also assume that template and table writes never overlap a run. The bench drives each value on a falling edge and keeps it until it sees ready. It loads coefficients and table entries only between runs. The properties place no limit on start. Because of that, the bench deliberately pulses start, with different parameters, in the middle of a run.

// File: rtl/cu_pkg.sv
package cu_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BIAS = 2'd1,
    ST_ACC  = 2'd2,
    ST_END  = 2'd3
  } seq_state_t;
endpackage

// File: rtl/cu_seq.sv
module cu_seq
  import cu_pkg::*;
#(
  parameter int TAPS = 9,
  parameter int IDXW = 4,
  parameter int ITW  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [ITW-1:0]  iter_cnt,
  input  logic            nb_valid,
  output logic            nb_ready,
  output logic            busy,
  output logic            done,
  output logic            run_go,
  output logic [IDXW-1:0] idx,
  output logic            uy,
  output logic            ld_bias,
  output logic            ld_add,
  output logic            ld_const,
  output logic            ld_reload,
  output logic            ld_out
);
  localparam logic [IDXW-1:0] BIAS_IDX = IDXW'(TAPS);
  localparam logic [IDXW-1:0] LAST_IDX = IDXW'(TAPS - 1);

  seq_state_t st;
  logic [ITW-1:0] left;

  assign busy      = (st != ST_IDLE);
  assign run_go    = (st == ST_IDLE) && start;
  assign nb_ready  = (st == ST_ACC);
  assign ld_bias   = (st == ST_BIAS);
  assign ld_add    = (st == ST_ACC) && nb_valid;
  assign ld_const  = (st == ST_END) && !uy;
  assign ld_reload = (st == ST_END) && uy;
  assign ld_out    = (st == ST_END) && uy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      idx  <= '0;
      uy   <= 1'b0;
      left <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st)
        ST_IDLE: if (start) begin
          idx  <= BIAS_IDX;
          uy   <= 1'b0;
          left <= iter_cnt;
          st   <= ST_BIAS;
        end
        ST_BIAS: begin
          idx <= '0;
          st  <= ST_ACC;
        end
        ST_ACC: if (nb_valid) begin
          if (idx == LAST_IDX) st <= ST_END;
          else                 idx <= idx + 1'b1;
        end
        ST_END: begin
          if (!uy) begin
            if (left == '0) begin
              st   <= ST_IDLE;
              done <= 1'b1;
            end else begin
              uy  <= 1'b1;
              idx <= '0;
              st  <= ST_ACC;
            end
          end else if (left == ITW'(1)) begin
            st   <= ST_IDLE;
            done <= 1'b1;
          end else begin
            left <= left - 1'b1;
            idx  <= '0;
            st   <= ST_ACC;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R7: done lasts exactly one cycle
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R2: the tap index never goes past the bias slot
  p_idx_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= BIAS_IDX);
endmodule

// File: rtl/cu_tmem.sv
module cu_tmem #(
  parameter int DW    = 8,
  parameter int IDXW  = 4,
  parameter int BASEW = 5,
  localparam int TAW  = BASEW + 2 + IDXW,
  localparam int DEPTH = 1 << TAW
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [TAW-1:0]   wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic [BASEW-1:0] base,
  input  logic             set_sel,
  input  logic             uy,
  input  logic [IDXW-1:0]  idx,
  output logic [DW-1:0]    coef
);
  logic [DW-1:0] mem [DEPTH];
  logic [TAW-1:0] rd_addr;

  assign rd_addr = {base, set_sel, uy, idx};
  assign coef    = mem[rd_addr];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end
endmodule

// File: rtl/cu_mac.sv
module cu_mac #(
  parameter int DW = 8,
  parameter int AW = 20
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 uy,
  input  logic                 ld_bias,
  input  logic                 ld_add,
  input  logic                 ld_const,
  input  logic                 ld_reload,
  input  logic signed [DW-1:0] coef,
  input  logic signed [DW-1:0] val,
  output logic signed [AW-1:0] acc
);
  localparam int PW = 2 * DW;

  logic signed [PW-1:0] prod;
  logic signed [AW-1:0] const_r;

  assign prod = coef * val;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc     <= '0;
      const_r <= '0;
    end else begin
      if (ld_bias)        acc <= {{(AW-DW){coef[DW-1]}}, coef};
      else if (ld_add)    acc <= acc + {{(AW-PW){prod[PW-1]}}, prod};
      else if (ld_reload) acc <= const_r;
      if (ld_const) const_r <= acc;
    end
  end

  // R3: the constant term is frozen during feedback iterations
  p_const_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    uy |=> $stable(const_r));
endmodule

// File: rtl/cu_lut.sv
module cu_lut #(
  parameter int DW = 8,
  parameter int AW = 20,
  localparam int DEPTH = 1 << DW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [DW-1:0]        wr_addr,
  input  logic [DW-1:0]        wr_data,
  input  logic signed [AW-1:0] acc,
  input  logic                 ld_out,
  output logic [DW-1:0]        y
);
  localparam logic signed [AW-1:0] SAT_HI = AW'((1 << (DW - 1)) - 1);
  localparam logic signed [AW-1:0] SAT_LO = ~SAT_HI;

  logic [DW-1:0] tbl [DEPTH];
  logic [DW-1:0] sidx;

  always_comb begin
    if (acc > SAT_HI)      sidx = SAT_HI[DW-1:0];
    else if (acc < SAT_LO) sidx = SAT_LO[DW-1:0];
    else                   sidx = acc[DW-1:0];
  end

  always_ff @(posedge clk) begin
    if (wr_en) tbl[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      y <= '0;
    else if (ld_out) y <= tbl[sidx];
  end
endmodule

// File: rtl/cell_compute_unit.sv
module cell_compute_unit #(
  parameter int DW    = 8,
  parameter int AW    = 20,
  parameter int IDXW  = 4,
  parameter int BASEW = 5,
  parameter int TAPS  = 9,
  parameter int ITW   = 4,
  localparam int TAW  = BASEW + 2 + IDXW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [ITW-1:0]   iter_cnt,
  input  logic             set_sel,
  input  logic [BASEW-1:0] tmpl_base,
  input  logic             tw_en,
  input  logic [TAW-1:0]   tw_addr,
  input  logic [DW-1:0]    tw_data,
  input  logic             lw_en,
  input  logic [DW-1:0]    lw_addr,
  input  logic [DW-1:0]    lw_data,
  input  logic             nb_valid,
  output logic             nb_ready,
  input  logic [DW-1:0]    nb_data,
  output logic [DW-1:0]    y_out,
  output logic             busy,
  output logic             done
);
  logic [IDXW-1:0]  idx;
  logic             uy, run_go;
  logic             ld_bias, ld_add, ld_const, ld_reload, ld_out;
  logic [DW-1:0]    coef;
  logic signed [AW-1:0] acc;
  logic             set_q;
  logic [BASEW-1:0] base_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      set_q  <= 1'b0;
      base_q <= '0;
    end else if (run_go) begin
      set_q  <= set_sel;
      base_q <= tmpl_base;
    end
  end

  cu_seq #(.TAPS(TAPS), .IDXW(IDXW), .ITW(ITW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .iter_cnt(iter_cnt),
    .nb_valid(nb_valid), .nb_ready(nb_ready), .busy(busy), .done(done),
    .run_go(run_go), .idx(idx), .uy(uy), .ld_bias(ld_bias),
    .ld_add(ld_add), .ld_const(ld_const), .ld_reload(ld_reload),
    .ld_out(ld_out)
  );

  cu_tmem #(.DW(DW), .IDXW(IDXW), .BASEW(BASEW)) u_tmem (
    .clk(clk), .wr_en(tw_en), .wr_addr(tw_addr), .wr_data(tw_data),
    .base(base_q), .set_sel(set_q), .uy(uy), .idx(idx), .coef(coef)
  );

  cu_mac #(.DW(DW), .AW(AW)) u_mac (
    .clk(clk), .rst_n(rst_n), .uy(uy), .ld_bias(ld_bias), .ld_add(ld_add),
    .ld_const(ld_const), .ld_reload(ld_reload), .coef(coef),
    .val(nb_data), .acc(acc)
  );

  cu_lut #(.DW(DW), .AW(AW)) u_lut (
    .clk(clk), .rst_n(rst_n), .wr_en(lw_en), .wr_addr(lw_addr),
    .wr_data(lw_data), .acc(acc), .ld_out(ld_out), .y(y_out)
  );

  // R6: values are taken only during a run
  p_ready_in_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
    nb_ready |-> busy);
  // R9: output holds while idle
  p_y_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(y_out));
  // R7: done follows a cycle in which the node was busy
  p_done_after_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy));
endmodule

// File: tb/cell_compute_unit_tb.sv
module cell_compute_unit_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [3:0] iter_cnt = '0;
  logic set_sel = 1'b0;
  logic [4:0] tmpl_base = '0;
  logic tw_en = 1'b0;
  logic [10:0] tw_addr = '0;
  logic [7:0] tw_data = '0;
  logic lw_en = 1'b0;
  logic [7:0] lw_addr = '0;
  logic [7:0] lw_data = '0;
  logic nb_valid = 1'b0;
  logic nb_ready;
  logic [7:0] nb_data = '0;
  logic [7:0] y_out;
  logic busy, done;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  logic signed [7:0] shadow [2048];
  logic [7:0] y_prev = '0;

  localparam int NV = 6;
  // seed, set, base, iterations
  localparam int VEC [NV][4] = '{
    '{3, 0, 0, 1}, '{17, 1, 0, 2}, '{5, 0, 7, 3},
    '{42, 1, 12, 1}, '{99, 0, 30, 2}, '{8, 1, 31, 4}
  };

  always #2 clk = ~clk;

  cell_compute_unit u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .iter_cnt(iter_cnt),
    .set_sel(set_sel), .tmpl_base(tmpl_base), .tw_en(tw_en),
    .tw_addr(tw_addr), .tw_data(tw_data), .lw_en(lw_en), .lw_addr(lw_addr),
    .lw_data(lw_data), .nb_valid(nb_valid), .nb_ready(nb_ready),
    .nb_data(nb_data), .y_out(y_out), .busy(busy), .done(done)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      total++; bad++;
      $display("FAIL watchdog expired act=%0d exp=<150000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int ta(input int base, input int set, input int uyf, input int tap);
    return base * 64 + set * 32 + uyf * 16 + tap;
  endfunction

  function automatic int vv(input int seed, input int it, input int k, input int fixv);
    if (fixv != 999) return fixv;
    return ((seed * 13 + it * 29 + k * 71) % 13) - 6;
  endfunction

  function automatic logic [7:0] lutv(input int i);
    return 8'((i * 5 + 3) & 255);
  endfunction

  // R2 R3 R4 R5 R7: reference result from the requirements
  function automatic logic [7:0] expect_y(input int seed, input int set, input int base,
                                          input int n, input int fixv, input logic [7:0] prev);
    int c, s;
    logic [7:0] y;
    c = int'(shadow[ta(base, set, 0, 9)]);
    for (int k = 0; k < 9; k++) c += int'(shadow[ta(base, set, 0, k)]) * vv(seed, 0, k, fixv);
    y = prev;
    for (int it = 1; it <= n; it++) begin
      s = c;
      for (int k = 0; k < 9; k++) s += int'(shadow[ta(base, set, 1, k)]) * vv(seed, it, k, fixv);
      if (s > 127) s = 127;
      if (s < -128) s = -128;
      y = lutv(s & 255);
    end
    return y;
  endfunction

  task automatic wt(input int a, input int v);
    @(negedge clk);
    tw_en = 1'b1; tw_addr = 11'(a); tw_data = 8'(v);
    shadow[a] = 8'(v);
    @(negedge clk);
    tw_en = 1'b0;
  endtask

  task automatic send(input int v);
    int guard;
    guard = 0;
    nb_valid = 1'b1; nb_data = 8'(v);
    while (!nb_ready && guard < 50) begin
      @(negedge clk); guard++;
    end
    @(negedge clk);
    nb_valid = 1'b0;
  endtask

  task automatic do_run(input int seed, input int set, input int base, input int n,
                        input int fixv, input bit poke, input string req);
    logic [7:0] e;
    int guard;
    e = expect_y(seed, set, base, n, fixv, y_prev);
    @(negedge clk);
    set_sel = set[0]; tmpl_base = 5'(base); iter_cnt = 4'(n); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R6 ready low after start", int'(nb_ready), 0);
    for (int it = 0; it <= n; it++) begin
      for (int k = 0; k < 9; k++) begin
        if (poke && it == 0 && k == 3) begin
          start = 1'b1; iter_cnt = 4'd0; set_sel = ~set[0]; tmpl_base = 5'(base + 1);
        end
        send(vv(seed, it, k, fixv));
        start = 1'b0;
      end
    end
    guard = 0;
    while (!done && guard < 20) begin
      @(negedge clk); guard++;
    end
    chk({req, " done pulse"}, int'(done), 1);
    chk({req, " y_out"}, int'(y_out), int'(e));
    chk("R7 idle at done", int'(busy), 0);
    @(negedge clk);
    chk("R7 done one cycle", int'(done), 0);
    chk("R6 ready low when idle", int'(nb_ready), 0);
    chk("R9 y_out holds", int'(y_out), int'(e));
    y_prev = e;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 y_out reset", int'(y_out), 0);
    chk("R1 busy reset", int'(busy), 0);
    chk("R1 done reset", int'(done), 0);
    chk("R1 ready reset", int'(nb_ready), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy after reset", int'(busy), 0);
    chk("R1 y_out after reset", int'(y_out), 0);

    // R10: load both stores through their ports
    for (int a = 0; a < 2048; a++) begin
      tw_en = 1'b1; tw_addr = 11'(a); tw_data = 8'(((a * 37 + 11) % 8) - 4);
      shadow[a] = 8'(((a * 37 + 11) % 8) - 4);
      @(negedge clk);
    end
    tw_en = 1'b0;
    for (int i = 0; i < 256; i++) begin
      lw_en = 1'b1; lw_addr = 8'(i); lw_data = lutv(i);
      @(negedge clk);
    end
    lw_en = 1'b0;

    // R2 R3 R4 R5: vector table
    for (int v = 0; v < NV; v++)
      do_run(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], 999, 1'b0, "R4 vector");

    // R4: repeating a run gives the same result
    do_run(17, 1, 0, 2, 999, 1'b0, "R4 repeat");
    // R8: start pulse with other parameters mid-run is ignored
    do_run(5, 0, 7, 3, 999, 1'b1, "R8 start while busy");
    // R7: zero iterations keeps y_out
    do_run(23, 1, 3, 0, 999, 1'b0, "R7 zero iterations");

    // R5: saturation corners with explicit coefficients at base 31 set 0
    for (int k = 0; k < 9; k++) begin
      wt(ta(31, 0, 0, k), 127);
      wt(ta(31, 0, 1, k), 0);
    end
    wt(ta(31, 0, 0, 9), 0);
    do_run(0, 0, 31, 1, 127, 1'b0, "R5 clamp high");
    chk("R5 clamp high index 127", int'(y_out), int'(lutv(127)));
    do_run(0, 0, 31, 2, -128, 1'b0, "R5 clamp low");
    chk("R5 clamp low index 0x80", int'(y_out), int'(lutv(128)));
    // R2 R3: bias alone, inputs weighted by zero
    for (int k = 0; k < 9; k++) wt(ta(31, 0, 0, k), 0);
    wt(ta(31, 0, 0, 9), -3);
    do_run(0, 0, 31, 1, 100, 1'b0, "R3 bias only");
    chk("R3 bias -3 index", int'(y_out), int'(lutv(253)));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule